// File: doc/BRIEF.md
# Selective Wait-State Clock Stretcher

This block is the bus glue for a 16-bit-address microprocessor with an 8-bit bank byte multiplexed onto its data bus. It runs from a fast master clock and produces two clocks from it. The free-running reference clock `gclk` toggles on every master edge. The processor clock `phi2` rises together with `gclk`, and its high phase is held for whole extra `gclk` periods only when the device being accessed is slow.

At the master edge where `phi2` rises, the block captures the address, the low two bank bits from the data bus and the read/write flag. It decodes the resulting 18-bit address into a 256 KB map of one-hot chip selects. It also settles how long the high phase will last. That length is one master cycle for fast devices. For slow devices it is three or five master cycles, chosen by `two_wait`. Read and write strobes and the data transceiver enable are active only while `phi2` is high. The bank byte therefore never meets a driven data bus.

Top module: `ws_glue`

## Requirements
- R1: While `rst_n` is low, `phi2`, `gclk`, every `sel` bit, `rd_stb`, `wr_stb` and `xcvr_en` are all 0.
- R2: `gclk` inverts on every master clock edge. Every rising edge of `phi2` coincides with a rising edge of `gclk`. `phi2` is low for exactly one master cycle between accesses.
- R3: An access to a device with no wait state holds `phi2` high for exactly one master cycle.
- R4: An access to a wait-stated device holds `phi2` high for 3 master cycles when `two_wait`=0 and for 5 when `two_wait`=1. With the default mask, the wait-stated selects are `sel[2]`, `sel[3]`, `sel[5]` and `sel[6]`.
- R5: The 18-bit address {bank, addr} decodes as follows: `sel[0]` for 0x00000–0x0BFFF, `sel[6]` for 0x0D000–0x0FFFF, and `sel[7]` for 0x10000–0x3FFFF.
- R6: The range 0x0C000–0x0CFFF is split into 256-byte slots by addr[11:8]. Slots 0..4 drive `sel[1]`..`sel[5]`. Slots 5..15 drive no select and are never stretched.
- R7: The expansion select `sel[4]` (slot 3) is never stretched, for either value of `two_wait`.
- R8: The bank is `data_in[1:0]`, taken at the edge where `phi2` rises, and it appears on `bank_a`. `data_in[7:2]` has no effect on decode or timing.
- R9: `sel` is nonzero only while `phi2` is high. At most one bit is set, and it does not change during a stretched high phase.
- R10: `rd_stb` is high when `phi2` is high, a select is active and the captured `rwb` is 1. `wr_stb` is high under the same conditions with `rwb` at 0.
- R11: `xcvr_en` is high only while `phi2` is high with a select active. It is low for the whole low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low synchronous reset |
| addr | input | 16 | processor address |
| data_in | input | 8 | data bus, carrying the bank byte during the low phase |
| rwb | input | 1 | 1 = read, 0 = write |
| two_wait | input | 1 | 0 = one-period stretch, 1 = two-period stretch |
| phi2 | output | 1 | stretched processor clock |
| gclk | output | 1 | unstretched reference clock |
| bank_a | output | 2 | latched bank bits A16–A17 |
| sel | output | 8 | one-hot chip selects |
| rd_stb | output | 1 | read strobe |
| wr_stb | output | 1 | write strobe |
| xcvr_en | output | 1 | data transceiver enable |

## Verification
The assertions assume that `addr`, `data_in`, `rwb` and `two_wait` are set up before the master edge that raises `phi2`, and that the processor keeps its address steady until the next low phase. The latched copy is therefore the only one that matters. The bench changes these inputs only at falling master edges that it observes during the low phase of `phi2`, so every captured value is settled. Random addresses are weighted toward the I/O block and mixed with random upper data bits so that slot decoding and bank aliasing are both exercised.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int NSEL      = 8;
  localparam int SEL_RAMLO = 0;
  localparam int SEL_IOA   = 1;
  localparam int SEL_IOB   = 2;
  localparam int SEL_IOC   = 3;
  localparam int SEL_XIOA  = 4;
  localparam int SEL_XIOB  = 5;
  localparam int SEL_ROM   = 6;
  localparam int SEL_RAMX  = 7;
  localparam int IO_SLOTS  = 5;

  typedef logic [NSEL-1:0] sel_t;

  // Map an 18-bit address onto a one-hot select vector
  function automatic sel_t map_decode(input logic [1:0] bank, input logic [15:0] a);
    sel_t s;
    s = '0;
    if (bank != 2'b00) begin
      s[SEL_RAMX] = 1'b1;
    end else if (a[15:12] == 4'hC) begin
      if (int'(a[11:8]) < IO_SLOTS) s[SEL_IOA + int'(a[11:8])] = 1'b1;
    end else if (a[15:14] == 2'b11) begin
      s[SEL_ROM] = 1'b1;
    end else begin
      s[SEL_RAMLO] = 1'b1;
    end
    return s;
  endfunction

  // Extra gclk periods the high phase is held for
  function automatic logic [1:0] stretch_units(input logic need, input logic two);
    if (!need) return 2'd0;
    return two ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/ws_decode.sv
module ws_decode
  import ws_pkg::*;
#(
  parameter logic [NSEL-1:0] WAIT_MASK = 8'b0110_1100
) (
  input  logic [1:0]      bank,
  input  logic [15:0]     addr,
  output logic [NSEL-1:0] sel_dec,
  output logic            need_wait
);
  // The expansion slot for fast peripherals is forced to run unstretched
  localparam logic [NSEL-1:0] EFF_MASK = WAIT_MASK & ~(NSEL'(1) << SEL_XIOA);

  always_comb begin
    sel_dec   = map_decode(bank, addr);
    need_wait = |(sel_dec & EFF_MASK);
  end
endmodule

// File: rtl/ws_clkgen.sv
module ws_clkgen
  import ws_pkg::*;
#(
  parameter int HOLD_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic need_wait,
  input  logic two_wait,
  output logic gclk,
  output logic phi2,
  output logic rise_evt
);
  logic              gclk_q, phi2_q;
  logic [HOLD_W-1:0] hold_q;

  // The next edge raises phi2 and is the capture point for the access
  assign rise_evt = !gclk_q && !phi2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gclk_q <= 1'b0;
      phi2_q <= 1'b0;
      hold_q <= '0;
    end else begin
      gclk_q <= ~gclk_q;
      if (!gclk_q) begin
        if (!phi2_q) begin
          phi2_q <= 1'b1;
          hold_q <= HOLD_W'(stretch_units(need_wait, two_wait));
        end
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end else begin
        phi2_q <= 1'b0;
      end
    end
  end

  assign gclk = gclk_q;
  assign phi2 = phi2_q;
endmodule

// File: rtl/ws_cycle_regs.sv
module ws_cycle_regs
  import ws_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise_evt,
  input  logic            phi2,
  input  logic [1:0]      bank_in,
  input  logic            rwb,
  input  logic [NSEL-1:0] sel_dec,
  input  logic            need_wait,
  output logic [1:0]      bank_a,
  output logic [NSEL-1:0] sel,
  output logic            rd_stb,
  output logic            wr_stb,
  output logic            xcvr_en,
  output logic            need_q
);
  logic [NSEL-1:0] sel_q;
  logic            rwb_q;
  logic            hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      rwb_q  <= 1'b1;
      bank_a <= '0;
      need_q <= 1'b0;
    end else if (rise_evt) begin
      sel_q  <= sel_dec;
      rwb_q  <= rwb;
      bank_a <= bank_in;
      need_q <= need_wait;
    end
  end

  assign hit     = phi2 && (sel_q != '0);
  assign sel     = phi2 ? sel_q : '0;
  assign rd_stb  = hit && rwb_q;
  assign wr_stb  = hit && !rwb_q;
  assign xcvr_en = hit;
endmodule

// File: rtl/ws_glue.sv
module ws_glue
  import ws_pkg::*;
#(
  parameter logic [NSEL-1:0] WAIT_MASK = 8'b0110_1100,
  parameter int              HOLD_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     addr,
  input  logic [7:0]      data_in,
  input  logic            rwb,
  input  logic            two_wait,
  output logic            phi2,
  output logic            gclk,
  output logic [1:0]      bank_a,
  output logic [NSEL-1:0] sel,
  output logic            rd_stb,
  output logic            wr_stb,
  output logic            xcvr_en
);
  logic [NSEL-1:0] sel_dec;
  logic            need_wait;
  logic            rise_evt;
  logic            need_q;
  logic [1:0]      bank_in;

  assign bank_in = data_in[1:0];

  ws_decode #(.WAIT_MASK(WAIT_MASK)) u_dec (
    .bank(bank_in), .addr(addr), .sel_dec(sel_dec), .need_wait(need_wait)
  );

  ws_clkgen #(.HOLD_W(HOLD_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .need_wait(need_wait), .two_wait(two_wait),
    .gclk(gclk), .phi2(phi2), .rise_evt(rise_evt)
  );

  ws_cycle_regs u_cyc (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .phi2(phi2),
    .bank_in(bank_in), .rwb(rwb), .sel_dec(sel_dec), .need_wait(need_wait),
    .bank_a(bank_a), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .xcvr_en(xcvr_en), .need_q(need_q)
  );
endmodule

// File: rtl/ws_glue_chk.sv
module ws_glue_chk
  import ws_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            phi2,
  input logic            gclk,
  input logic [NSEL-1:0] sel,
  input logic            rd_stb,
  input logic            wr_stb,
  input logic            xcvr_en,
  input logic            rise_evt,
  input logic            need_q
);
  // R2
  phi2_rise_with_gclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi2) |-> $rose(gclk));
  // R2
  rise_event_lifts_phi2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (phi2 && gclk));
  // R3
  fast_access_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phi2) && !need_q) |=> !phi2);
  // R4
  slow_access_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phi2) && need_q) |=> phi2);
  // R7
  xioa_never_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phi2) && sel[SEL_XIOA]) |=> !phi2);
  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  // R9
  sel_only_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0) |-> phi2);
  // R9
  sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && $past(phi2)) |-> $stable(sel));
  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  // R10
  strobe_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (phi2 && sel != '0));
  // R11
  xcvr_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_en |-> phi2);
endmodule

bind ws_glue ws_glue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .gclk(gclk), .sel(sel),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .xcvr_en(xcvr_en),
  .rise_evt(rise_evt), .need_q(need_q)
);

// File: tb/tb_ws_glue.sv
module tb_ws_glue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data_in = '0;
  logic        rwb = 1'b1;
  logic        two_wait = 1'b0;
  logic        phi2, gclk, rd_stb, wr_stb, xcvr_en;
  logic [1:0]  bank_a;
  logic [7:0]  sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ws_glue dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in), .rwb(rwb),
    .two_wait(two_wait), .phi2(phi2), .gclk(gclk), .bank_a(bank_a),
    .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb), .xcvr_en(xcvr_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected select for an 18-bit address, by address ranges
  function automatic logic [7:0] exp_sel(input logic [17:0] a);
    int slot;
    if (a >= 18'h10000) return 8'h80;
    if (a >= 18'h0D000) return 8'h40;
    if (a >= 18'h0C000) begin
      slot = int'((a - 18'h0C000) >> 8);
      if (slot < 5) return 8'(1 << (slot + 1));
      return 8'h00;
    end
    return 8'h01;
  endfunction

  function automatic int exp_high(input logic [7:0] s, input bit two);
    bit slow;
    slow = (s == 8'h04) || (s == 8'h08) || (s == 8'h20) || (s == 8'h40);
    if (!slow) return 1;
    return two ? 5 : 3;
  endfunction

  // Drive one access during the low phase and check the whole high phase
  task automatic access(input logic [17:0] a, input logic [5:0] junk,
                        input bit rd, input bit two);
    logic [7:0] es;
    int eh, nh;
    es = exp_sel(a);
    eh = exp_high(es, two);
    addr = a[15:0];
    data_in = {junk, a[17:16]};
    rwb = rd;
    two_wait = two;
    nh = 0;
    @(negedge clk);
    chk(phi2 === 1'b1 && gclk === 1'b1, "R2", "phi2/gclk rise together",
        {phi2, gclk}, 3);
    chk(bank_a === a[17:16], "R8", "bank latch", bank_a, a[17:16]);
    while (phi2 === 1'b1 && nh < 12) begin
      chk(sel === es, "R5", "select during high", sel, es);
      chk(gclk === ((nh % 2) == 0), "R2", "gclk phase", gclk, (nh % 2) == 0);
      chk(rd_stb === (rd && es != 0), "R10", "read strobe", rd_stb, rd && es != 0);
      chk(wr_stb === (!rd && es != 0), "R10", "write strobe", wr_stb, !rd && es != 0);
      chk(xcvr_en === (es != 0), "R11", "xcvr during high", xcvr_en, es != 0);
      nh++;
      @(negedge clk);
    end
    if (es == 8'h10) chk(nh == 1, "R7", "expansion not stretched", nh, 1);
    else if (eh == 1) chk(nh == eh, "R3", "fast high length", nh, eh);
    else chk(nh == eh, "R4", "slow high length", nh, eh);
    chk(sel === 8'h00 && xcvr_en === 1'b0 && !rd_stb && !wr_stb, "R11",
        "quiet low phase", {sel, xcvr_en, rd_stb, wr_stb}, 0);
    chk(gclk === 1'b0, "R2", "gclk low in low phase", gclk, 0);
  endtask

  initial begin
    int n;
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] a;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // R1
    chk(phi2 === 0 && gclk === 0 && sel === 0 && !rd_stb && !wr_stb && !xcvr_en,
        "R1", "reset state", {phi2, gclk, sel, rd_stb, wr_stb, xcvr_en}, 0);
    addr = 16'h0000;
    data_in = 8'h00;
    rst_n = 1'b1;  // next posedge raises phi2, so set inputs before it
    // Directed corners
    access(18'h00000, 6'h00, 1'b1, 1'b0);  // R5 low RAM
    access(18'h0BFFF, 6'h00, 1'b0, 1'b1);  // R5 low RAM top
    access(18'h0C0FF, 6'h00, 1'b1, 1'b1);  // R6 slot0 fast
    access(18'h0C100, 6'h00, 1'b1, 1'b0);  // R4 slot1, one period
    access(18'h0C200, 6'h00, 1'b0, 1'b1);  // R4 slot2, two periods
    access(18'h0C300, 6'h00, 1'b1, 1'b1);  // R7 expansion, two_wait set
    access(18'h0C3FF, 6'h00, 1'b0, 1'b0);  // R7
    access(18'h0C400, 6'h00, 1'b1, 1'b1);  // R4 second expansion
    access(18'h0C500, 6'h00, 1'b1, 1'b1);  // R6 unmapped slot
    access(18'h0CFFF, 6'h00, 1'b0, 1'b1);  // R6 unmapped slot top
    access(18'h0D000, 6'h00, 1'b1, 1'b0);  // R4 ROM
    access(18'h0FFFF, 6'h00, 1'b1, 1'b1);  // R4 ROM top
    access(18'h10000, 6'h3F, 1'b0, 1'b1);  // R8 junk upper bits
    access(18'h3FFFF, 6'h2A, 1'b1, 1'b0);  // R8 bank 3
    access(18'h0C200, 6'h3F, 1'b1, 1'b0);  // R8 junk ignored on bank 0
    // Random mix
    for (int i = 0; i < 400; i++) begin
      a = 18'($urandom);
      if (($urandom % 3) == 0) a = {2'b00, 4'hC, a[11:0]};
      access(a, 6'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule